// File: doc/BRIEF.md
# Two-Partition Flash Command Controller

This block controls a byte-wide flash store that is split into two partitions. The larger partition holds program code and coefficients. The smaller partition holds user information. A serial front end sends 8-bit commands together with a 12-bit address and a data byte. The controller decodes each command into one of these actions: a partition-select step, an erase of the whole selected partition, an erase of one 64-byte page, or the programming of one byte. It applies the action to a behavioural array model.

Erase and program each take a fixed number of clock cycles. The busy flag is high for that whole time. A processor-side port gives read-only access to the program partition. A serial-side read port returns bytes from whichever partition is selected.

A byte must be erased to FFh before it can be programmed. Programming can only clear bits, never set them. This gives the same result as a real flash cell and needs no read-modify-write at the edge of the block.

Top module: `pflash_cmd_ctrl`

## Requirements
- R1: After reset, partition 0 is selected, `busy_o` is low, and both read outputs hold FFh.
- R2: Command F8h selects partition 1 only when the command accepted just before it was the halt command 78h. If F8h arrives in any other position, the selection does not change.
- R3: An accepted halt command 78h always selects partition 0, whichever partition was selected before.
- R4: Command E8h sets every byte of the selected partition to FFh. The other partition is left unchanged.
- R5: Command D8h sets the 64 bytes of one page of the selected partition to FFh. The page index is address bits [11:6], taken modulo the page count of the selected partition. The neighbouring pages are left unchanged.
- R6: In partition 1, which has two pages, a page erase chooses its page with address bit 6 alone. Higher address bits never reach any other storage.
- R7: Command C8h programs the byte at the given address in the selected partition. The new stored value is the old value AND the write data. Partition 1 uses address bits [6:0].
- R8: An accepted erase or program drives `busy_o` high for exactly OP_CYCLES cycles, starting on the cycle after it is accepted. The array contents change at the clock edge where `busy_o` falls.
- R9: Every command that arrives while `busy_o` is high is ignored. This covers partition-select commands, and it includes the running operation: such a command does not extend it.
- R10: The processor port reads partition 0 only, whatever partition is selected. Its result appears one cycle after the address is applied. It returns FFh for any read taken while busy.
- R11: The serial read port returns the byte at `addr_i` in the selected partition, one cycle after the address is applied. It returns FFh while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_i | input | 8 | Command code |
| addr_i | input | 12 | Address register: operation target and serial read address |
| wdata_i | input | 8 | Program data |
| cpu_addr_i | input | 12 | Processor read address into partition 0 |
| cpu_rdata_o | output | 8 | Processor read data, registered |
| ser_rdata_o | output | 8 | Serial read data from the selected partition, registered |
| busy_o | output | 1 | Erase or program in progress |
| part_o | output | 1 | Selected partition (0 or 1) |

## Verification
The bench builds the block with P0_PAGES=8, P1_PAGES=2, PAGE_BYTES=64 and OP_CYCLES=4. With only eight pages in partition 0, page-index wrapping and a full-partition erase can be checked in a few cycles. A four-cycle busy window lets the bench land an ignored command, and a processor read, inside the window at known cycle offsets. Partition 1 keeps its two pages, so the bench can send a page-erase address whose upper bits are all set and confirm that only address bit 6 picks the page.

// File: rtl/pflash_pkg.sv
package pflash_pkg;
  localparam logic [7:0] CMD_HALT       = 8'h78;
  localparam logic [7:0] CMD_SWITCH     = 8'hF8;
  localparam logic [7:0] CMD_ERASE_ALL  = 8'hE8;
  localparam logic [7:0] CMD_ERASE_PAGE = 8'hD8;
  localparam logic [7:0] CMD_PROG       = 8'hC8;
  localparam logic [7:0] BLANK          = 8'hFF;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_ERASE_ALL,
    OP_ERASE_PAGE,
    OP_PROG
  } op_e;
endpackage

// File: rtl/pflash_part_sel.sv
module pflash_part_sel
  import pflash_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       acc_i,
  input  logic [7:0] cmd_i,
  output logic       part_o
);
  logic armed_q, part_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      part_q  <= 1'b0;
    end else if (acc_i) begin
      armed_q <= (cmd_i == CMD_HALT);
      if (cmd_i == CMD_HALT)
        part_q <= 1'b0;
      else if (cmd_i == CMD_SWITCH && armed_q)
        part_q <= 1'b1;
    end
  end

  assign part_o = part_q;

  AST_HALT_SELECTS_P0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && cmd_i == CMD_HALT |=> !part_o) else $error("halt"); // R3
  AST_SWITCH_AFTER_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && cmd_i == CMD_SWITCH && armed_q |=> part_o) else $error("switch"); // R2
  AST_SWITCH_NEEDS_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && cmd_i == CMD_SWITCH && !armed_q |=> $stable(part_o)) else $error("stray switch"); // R2
endmodule

// File: rtl/pflash_op_seq.sv
module pflash_op_seq
  import pflash_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int OP_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic [7:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              part_i,
  output logic              busy_o,
  output logic              commit_o,
  output op_e               op_o,
  output logic              tgt_part_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        wdata_o
);
  localparam int CNT_W = $clog2(OP_CYCLES + 1);

  logic [CNT_W-1:0]  cnt_q;
  op_e               op_q, op_dec;
  logic              part_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;

  always_comb begin
    unique case (cmd_i)
      CMD_ERASE_ALL:  op_dec = OP_ERASE_ALL;
      CMD_ERASE_PAGE: op_dec = OP_ERASE_PAGE;
      CMD_PROG:       op_dec = OP_PROG;
      default:        op_dec = OP_NONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      op_q   <= OP_NONE;
      part_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (acc_i && op_dec != OP_NONE) begin
      cnt_q  <= CNT_W'(OP_CYCLES);
      op_q   <= op_dec;
      part_q <= part_i;
      addr_q <= addr_i;
      data_q <= wdata_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign busy_o     = (cnt_q != '0);
  assign commit_o   = (cnt_q == CNT_W'(1));
  assign op_o       = op_q;
  assign tgt_part_o = part_q;
  assign addr_o     = addr_q;
  assign wdata_o    = data_q;

  AST_BUSY_COUNTDOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != '0 |=> cnt_q == $past(cnt_q) - CNT_W'(1)) else $error("countdown"); // R8
  AST_LOAD_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && op_dec != OP_NONE |=> cnt_q == CNT_W'(OP_CYCLES)) else $error("load"); // R8
endmodule

// File: rtl/pflash_bank.sv
module pflash_bank
  import pflash_pkg::*;
#(
  parameter int PAGES      = 64,
  parameter int PAGE_BYTES = 64,
  parameter int NRD        = 1,
  localparam int DEPTH     = PAGES * PAGE_BYTES,
  localparam int IDX_W     = $clog2(DEPTH),
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PG_W      = IDX_W - OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             erase_all_i,
  input  logic             erase_pg_i,
  input  logic             prog_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       wdata_i,
  input  logic [IDX_W-1:0] rd_idx_i [NRD],
  output logic [7:0]       rd_data_o [NRD]
);
  logic [7:0]      mem [DEPTH];
  logic [PG_W-1:0] pg;

  assign pg = idx_i[IDX_W-1:OFF_W];

  always_ff @(posedge clk_i) begin
    if (erase_all_i) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= BLANK;
    end else if (erase_pg_i) begin
      for (int j = 0; j < PAGE_BYTES; j++) mem[{pg, OFF_W'(j)}] <= BLANK;
    end else if (prog_i) begin
      mem[idx_i] <= mem[idx_i] & wdata_i;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_data_o[r] = mem[rd_idx_i[r]];
  end

  AST_PROG_AND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_i && !erase_all_i && !erase_pg_i |=>
      mem[$past(idx_i)] == ($past(mem[idx_i]) & $past(wdata_i))) else $error("prog"); // R7
  AST_PAGE_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_pg_i && !erase_all_i |=>
      mem[{$past(pg), {OFF_W{1'b1}}}] == BLANK && mem[{$past(pg), {OFF_W{1'b0}}}] == BLANK)
    else $error("page"); // R5
endmodule

// File: rtl/pflash_cmd_ctrl.sv
module pflash_cmd_ctrl
  import pflash_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 64,
  parameter int P0_PAGES   = 64,
  parameter int P1_PAGES   = 2,
  parameter int OP_CYCLES  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [7:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  output logic [7:0]        cpu_rdata_o,
  output logic [7:0]        ser_rdata_o,
  output logic              busy_o,
  output logic              part_o
);
  localparam int IDX0_W = $clog2(P0_PAGES * PAGE_BYTES);
  localparam int IDX1_W = $clog2(P1_PAGES * PAGE_BYTES);

  logic              acc, busy, commit, tgt_part;
  op_e               op;
  logic [ADDR_W-1:0] op_addr;
  logic [7:0]        op_data;
  logic [IDX0_W-1:0] rd0_idx  [2];
  logic [7:0]        rd0_data [2];
  logic [IDX1_W-1:0] rd1_idx  [1];
  logic [7:0]        rd1_data [1];
  logic [1:0]        ea, ep, pr;
  logic [7:0]        cpu_q, ser_q;

  assign acc = cmd_valid_i && !busy;

  pflash_part_sel u_part (
    .clk_i, .rst_ni, .acc_i(acc), .cmd_i, .part_o
  );

  pflash_op_seq #(.ADDR_W(ADDR_W), .OP_CYCLES(OP_CYCLES)) u_seq (
    .clk_i, .rst_ni, .acc_i(acc), .cmd_i, .addr_i, .wdata_i, .part_i(part_o),
    .busy_o(busy), .commit_o(commit), .op_o(op), .tgt_part_o(tgt_part),
    .addr_o(op_addr), .wdata_o(op_data)
  );

  for (genvar k = 0; k < 2; k++) begin : g_strobe
    logic hit;
    assign hit   = commit && (tgt_part == k[0]);
    assign ea[k] = hit && (op == OP_ERASE_ALL);
    assign ep[k] = hit && (op == OP_ERASE_PAGE);
    assign pr[k] = hit && (op == OP_PROG);
  end

  assign rd0_idx[0] = addr_i[IDX0_W-1:0];
  assign rd0_idx[1] = cpu_addr_i[IDX0_W-1:0];
  assign rd1_idx[0] = addr_i[IDX1_W-1:0];

  pflash_bank #(.PAGES(P0_PAGES), .PAGE_BYTES(PAGE_BYTES), .NRD(2)) u_bank0 (
    .clk_i, .rst_ni, .erase_all_i(ea[0]), .erase_pg_i(ep[0]), .prog_i(pr[0]),
    .idx_i(op_addr[IDX0_W-1:0]), .wdata_i(op_data),
    .rd_idx_i(rd0_idx), .rd_data_o(rd0_data)
  );

  pflash_bank #(.PAGES(P1_PAGES), .PAGE_BYTES(PAGE_BYTES), .NRD(1)) u_bank1 (
    .clk_i, .rst_ni, .erase_all_i(ea[1]), .erase_pg_i(ep[1]), .prog_i(pr[1]),
    .idx_i(op_addr[IDX1_W-1:0]), .wdata_i(op_data),
    .rd_idx_i(rd1_idx), .rd_data_o(rd1_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_q <= BLANK;
      ser_q <= BLANK;
    end else begin
      cpu_q <= busy ? BLANK : rd0_data[1];
      ser_q <= busy ? BLANK : (part_o ? rd1_data[0] : rd0_data[0]);
    end
  end

  assign cpu_rdata_o = cpu_q;
  assign ser_rdata_o = ser_q;
  assign busy_o      = busy;

  AST_CPU_BLANK_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> cpu_rdata_o == BLANK) else $error("cpu busy"); // R10
  AST_PART_HOLD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(part_o)) else $error("part busy"); // R9
  AST_ONE_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({ea, ep, pr}) <= 1) else $error("multi strobe"); // R4
endmodule

// File: tb/tb_pflash_cmd_ctrl.sv
module tb_pflash_cmd_ctrl;
  localparam int OPC = 4;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [7:0] cmd = 0, wdata = 0, cpu_rdata, ser_rdata;
  logic [11:0] addr = 0, cpu_addr = 0;
  logic busy, part;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  pflash_cmd_ctrl #(.ADDR_W(12), .PAGE_BYTES(64), .P0_PAGES(8), .P1_PAGES(2),
                    .OP_CYCLES(OPC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .addr_i(addr), .wdata_i(wdata), .cpu_addr_i(cpu_addr),
    .cpu_rdata_o(cpu_rdata), .ser_rdata_o(ser_rdata), .busy_o(busy), .part_o(part)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(logic [7:0] c, logic [11:0] a = 0, logic [7:0] d = 0);
    cmd = c; addr = a; wdata = d; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic idle();
    while (busy) @(negedge clk);
  endtask

  task automatic run(logic [7:0] c, logic [11:0] a = 0, logic [7:0] d = 0);
    send(c, a, d); idle();
  endtask

  task automatic sread(logic [11:0] a, output logic [7:0] v);
    addr = a; @(negedge clk); v = ser_rdata;
  endtask

  task automatic cread(logic [11:0] a, output logic [7:0] v);
    cpu_addr = a; @(negedge clk); v = cpu_rdata;
  endtask

  task automatic t_reset();
    chk("R1 part", part, 0);
    chk("R1 busy", busy, 0);
    chk("R1 cpu", cpu_rdata, 8'hFF);
    chk("R1 ser", ser_rdata, 8'hFF);
  endtask

  task automatic t_erase_all_p0();
    logic [7:0] v;
    int n = 0;
    send(8'hE8);
    while (busy) begin n++; @(negedge clk); end
    chk("R8 busy length", n, OPC);
    sread(12'h000, v); chk("R4 first", v, 8'hFF);
    sread(12'h1FF, v); chk("R4 last", v, 8'hFF);
  endtask

  task automatic t_program();
    logic [7:0] v;
    run(8'hC8, 12'h010, 8'hA5);
    sread(12'h010, v); chk("R7 prog", v, 8'hA5);
    run(8'hC8, 12'h010, 8'h0F);
    sread(12'h010, v); chk("R7 and", v, 8'h05);
    cread(12'h010, v); chk("R10 cpu read", v, 8'h05);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] v;
    send(8'hC8, 12'h020, 8'h3C);
    cread(12'h010, v); chk("R10 cpu busy", v, 8'hFF);
    send(8'hC8, 12'h021, 8'h00);
    send(8'h78);
    chk("R8 still busy", busy, 1);
    @(negedge clk);
    chk("R9 not extended", busy, 0);
    sread(12'h021, v); chk("R9 ignored prog", v, 8'hFF);
    sread(12'h020, v); chk("R7 accepted prog", v, 8'h3C);
    run(8'h78); send(8'hC8, 12'h022, 8'h00); send(8'hF8);
    idle();
    chk("R9 switch ignored", part, 0);
  endtask

  task automatic t_page_erase();
    logic [7:0] v;
    run(8'hC8, 12'h0C0, 8'h00); run(8'hC8, 12'h0FF, 8'h00);
    run(8'hC8, 12'h100, 8'h00); run(8'hC8, 12'h0BF, 8'h00);
    run(8'hD8, 12'h8C5);
    sread(12'h0C0, v); chk("R5 page start", v, 8'hFF);
    sread(12'h0FF, v); chk("R5 page end", v, 8'hFF);
    sread(12'h100, v); chk("R5 next page", v, 8'h00);
    sread(12'h0BF, v); chk("R5 prev page", v, 8'h00);
  endtask

  task automatic t_switch();
    send(8'hF8); chk("R2 stray switch", part, 0);
    send(8'h78); send(8'h00); send(8'hF8); chk("R2 gap", part, 0);
    send(8'h78); send(8'hF8); chk("R2 switch", part, 1);
  endtask

  task automatic t_p1();
    logic [7:0] v;
    run(8'hE8);
    sread(12'h000, v); chk("R4 p1 first", v, 8'hFF);
    sread(12'h07F, v); chk("R4 p1 last", v, 8'hFF);
    run(8'hC8, 12'h005, 8'h11); run(8'hC8, 12'h045, 8'h22);
    sread(12'h045, v); chk("R7 p1 prog", v, 8'h22);
    cread(12'h010, v); chk("R10 cpu sees p0", v, 8'h05);
    run(8'hD8, 12'hFC5);
    sread(12'h045, v); chk("R6 wrap page", v, 8'hFF);
    sread(12'h005, v); chk("R6 other page", v, 8'h11);
    send(8'h78); chk("R3 halt to p0", part, 0);
    sread(12'h1C5, v); chk("R6 p0 untouched", v, 8'hFF);
    sread(12'h100, v); chk("R4 p0 kept", v, 8'h00);
    run(8'hE8);
    send(8'h78); send(8'hF8);
    sread(12'h005, v); chk("R4 p1 kept", v, 8'h11);
    chk("R11 serial sel", part, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_erase_all_p0();
    t_program();
    t_busy_ignore();
    t_page_erase();
    t_switch();
    t_p1();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule